// File: doc/BRIEF.md
# Single-Slope Conversion Timer

This block is the digital half of a four-channel single-slope converter. A capacitor charged by a constant current forms a shared ramp. Four comparators, one per channel, each go high when the ramp passes that channel's input. A start pulse discharges the capacitor for a programmable number of clocks. It then clears a shared 12-bit counter and lets it run. When a channel's comparator first goes high, the block stores the counter value in that channel's result register. The stored count is proportional to the channel's input voltage.

The fourth channel sits behind an external four-way selector. Its select code comes from the mode register, and code 3 routes the internal reference so that the ramp slope can be calibrated. The block also drives a 3-bit trim code to the current source. The mode register selects the count rate: the full clock rate, or half of it. The analog parts (ramp, comparators, selector and current source) are outside the block.

Top module: `ssadc_timer`

## Requirements
- R1: After reset, every result and status read returns 0. `done_o`, `ovf_o`, `ramp_rst_o`, `aux_sel_o` and `trim_o` are 0. Comparator edges seen before the first start pulse capture nothing.
- R2: Address 0 is the mode register: bit 7 is the fast-count flag and bits 1:0 drive `aux_sel_o`. The codes are 0 for auxiliary input 0, 1 for auxiliary input 1, 2 for auxiliary input 2 and 3 for the internal reference. Address 1 bits 2:0 drive `trim_o`. Address 2 bits 7:0 hold the discharge width W. Unused bits read 0. Read data appears on `reg_rdata` one clock after the address is presented.
- R3: A clock edge that samples `sync_i` high after it was low is the start edge E0. It clears all results, overflow flags and done. `ramp_rst_o` is then high for exactly max(W,1) cycles, during which the counter holds at 0.
- R4: Let j be the number of edges after the end of the discharge (edge E0+Weff+j). With the fast flag set, the counter value is then j. With the flag clear, it is floor(j/2).
- R5: Suppose a comparator input goes high after edge E0+d and d+2 >= Weff. The channel then stores the counter value present after edge E0+d+2. This value is d+2-Weff in fast mode, and half of that rounded down in slow mode. Results read at address 4+channel, with the count in bits 11:0 and the overflow flag in bit 15.
- R6: Only the first captured rising edge per channel counts. Later toggles leave the result unchanged until the next start edge.
- R7: A comparator rising edge whose capture would fall while `ramp_rst_o` is high (d+2 < Weff) is ignored. A later rising edge after the discharge is captured normally.
- R8: The counter stops at 4095. Any channel not yet captured then stores 4095 and sets its bit in `ovf_o` and bit 15 of its result.
- R9: `done_o` (also bit 0 of status address 3) goes high once every channel has captured or saturated. It clears at the next start edge. Status bits 7:4 mirror `ovf_o`.
- R10: Writes to addresses 3 to 7 change no result or status value.
- R11: A start edge during a conversion restarts it: done drops and the old results clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the fast count rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Start pulse; its rising edge starts a conversion |
| cmp_i | input | 4 | Comparator outputs, one per channel (bit 3 is the auxiliary channel) |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| ramp_rst_o | output | 1 | Capacitor discharge control |
| aux_sel_o | output | 2 | Auxiliary selector code |
| trim_o | output | 3 | Current-source trim code |
| done_o | output | 1 | All channels captured or saturated |
| ovf_o | output | 4 | Per-channel saturation flags |

## Verification
The hardest case to reach from the ports is the boundary between a comparator edge that is dropped because it falls inside the discharge window and one that is captured at count zero. The bench reaches it by placing each channel's edge at a delay measured from the start edge and derived from the programmed width, starting two cycles before the end of the discharge. It sweeps that offset across widths and both count rates. Saturation requires letting the counter run all the way to 4095 with three comparators held low. A separate test restarts a conversion partway through to show that the old state clears.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

  localparam int AUX_W        = 2;
  localparam int TRIM_W       = 3;
  localparam int ADDR_MODE    = 0;
  localparam int ADDR_TRIM    = 1;
  localparam int ADDR_WIDTH   = 2;
  localparam int ADDR_STAT    = 3;
  localparam int RES_BASE     = 4;
  localparam int MODE_FAST    = 7;
  localparam int STAT_OVF_LSB = 4;

  typedef enum logic [AUX_W-1:0] {
    AUX_IN0  = 2'd0,
    AUX_IN1  = 2'd1,
    AUX_IN2  = 2'd2,
    AUX_VREF = 2'd3
  } aux_sel_e;

  // discharge length in cycles: a zero setting still gives one cycle
  function automatic int hold_cycles(int w);
    return (w == 0) ? 1 : w;
  endfunction

  // counter advances every cycle in fast mode, every second cycle otherwise
  function automatic logic step_now(logic fast, logic phase);
    return fast | phase;
  endfunction

endpackage

// File: rtl/ssadc_edge_sync.sv
module ssadc_edge_sync #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmp_i,
  output logic [NCH-1:0] rise_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= cmp_i[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign rise_o[i] = s2 & ~prev;
  end

endmodule

// File: rtl/ssadc_ramp_ctl.sv
module ssadc_ramp_ctl
  import ssadc_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int SW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             fast_i,
  input  logic [SW_W-1:0]  width_i,
  output logic             sync_evt_o,
  output logic             run_o,
  output logic             cnt_inc_o,
  output logic             at_max_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ramp_rst_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             sync_q;
  logic             armed;
  logic             phase;
  logic [SW_W-1:0]  hold_cnt;
  logic [CNT_W-1:0] cnt;

  assign sync_evt_o = sync_i & ~sync_q;
  assign run_o      = armed && (hold_cnt == '0);
  assign at_max_o   = (cnt == CNT_MAX);
  assign cnt_inc_o  = run_o && !sync_evt_o && !at_max_o && step_now(fast_i, phase);
  assign cnt_o      = cnt;
  assign ramp_rst_o = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      armed    <= 1'b0;
      phase    <= 1'b0;
      hold_cnt <= '0;
      cnt      <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_evt_o) begin
        armed    <= 1'b1;
        phase    <= 1'b0;
        cnt      <= '0;
        hold_cnt <= SW_W'(hold_cycles(int'(width_i)));
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - SW_W'(1);
      end else if (armed) begin
        phase <= ~phase;
        if (cnt_inc_o) cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ssadc_capture.sv
module ssadc_capture #(
  parameter int NCH   = 4,
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_evt_i,
  input  logic                 run_i,
  input  logic                 at_max_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [NCH-1:0]       rise_i,
  output logic [NCH-1:0]       trip_o,
  output logic [NCH-1:0]       sat_o,
  output logic [NCH-1:0]       cap_mask_o,
  output logic [NCH-1:0]       ovf_o,
  output logic [NCH*CNT_W-1:0] res_flat_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] res;
    logic             cap;
    logic             ovf;

    assign trip_o[i] = run_i && !sync_evt_i && !cap && rise_i[i];
    assign sat_o[i]  = run_i && !sync_evt_i && !cap && !rise_i[i] && at_max_i;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res <= '0;
        cap <= 1'b0;
        ovf <= 1'b0;
      end else if (sync_evt_i) begin
        res <= '0;
        cap <= 1'b0;
        ovf <= 1'b0;
      end else if (trip_o[i]) begin
        res <= cnt_i;
        cap <= 1'b1;
      end else if (sat_o[i]) begin
        res <= CNT_MAX;
        cap <= 1'b1;
        ovf <= 1'b1;
      end
    end

    assign cap_mask_o[i]                  = cap;
    assign ovf_o[i]                       = ovf;
    assign res_flat_o[i*CNT_W +: CNT_W]   = res;
  end

endmodule

// File: rtl/ssadc_regs.sv
module ssadc_regs
  import ssadc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 12,
  parameter int AW    = 3,
  parameter int DW    = 16,
  parameter int SW_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr_i,
  input  logic                 we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NCH*CNT_W-1:0] res_flat_i,
  input  logic [NCH-1:0]       ovf_i,
  input  logic                 done_i,
  output logic                 fast_o,
  output aux_sel_e             aux_sel_o,
  output logic [TRIM_W-1:0]    trim_o,
  output logic [SW_W-1:0]      width_o
);

  logic          unused_wdata;
  logic [DW-1:0] rd_next;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_o    <= 1'b0;
      aux_sel_o <= AUX_IN0;
      trim_o    <= '0;
      width_o   <= '0;
    end else if (we_i) begin
      if (int'(addr_i) == ADDR_MODE) begin
        fast_o    <= wdata_i[MODE_FAST];
        aux_sel_o <= aux_sel_e'(wdata_i[AUX_W-1:0]);
      end
      if (int'(addr_i) == ADDR_TRIM)  trim_o  <= wdata_i[TRIM_W-1:0];
      if (int'(addr_i) == ADDR_WIDTH) width_o <= wdata_i[SW_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (int'(addr_i) == ADDR_MODE) begin
      rd_next[MODE_FAST]   = fast_o;
      rd_next[AUX_W-1:0]   = aux_sel_o;
    end
    if (int'(addr_i) == ADDR_TRIM)  rd_next[TRIM_W-1:0] = trim_o;
    if (int'(addr_i) == ADDR_WIDTH) rd_next[SW_W-1:0]   = width_o;
    if (int'(addr_i) == ADDR_STAT) begin
      rd_next[0]                    = done_i;
      rd_next[STAT_OVF_LSB +: NCH]  = ovf_i;
    end
    for (int i = 0; i < NCH; i++) begin
      if (int'(addr_i) == RES_BASE + i) begin
        rd_next[CNT_W-1:0] = res_flat_i[i*CNT_W +: CNT_W];
        rd_next[DW-1]      = ovf_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_next;
  end

endmodule

// File: rtl/ssadc_timer.sv
module ssadc_timer
  import ssadc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 12,
  parameter int AW    = 3,
  parameter int DW    = 16,
  parameter int SW_W  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_i,
  input  logic [NCH-1:0] cmp_i,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           ramp_rst_o,
  output logic [1:0]     aux_sel_o,
  output logic [2:0]     trim_o,
  output logic           done_o,
  output logic [NCH-1:0] ovf_o
);

  // named internal events, observed by the bound checker
  logic                 sync_evt;
  logic                 run;
  logic                 cnt_inc;
  logic                 at_max;
  logic [CNT_W-1:0]     cnt;
  logic [NCH-1:0]       rise;
  logic [NCH-1:0]       trip;
  logic [NCH-1:0]       sat;
  logic [NCH-1:0]       cap_mask;
  logic [NCH*CNT_W-1:0] res_flat;
  logic                 fast_mode;
  logic [SW_W-1:0]      width;
  aux_sel_e             aux_sel;

  ssadc_edge_sync #(.NCH(NCH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_i  (cmp_i),
    .rise_o (rise)
  );

  ssadc_ramp_ctl #(.CNT_W(CNT_W), .SW_W(SW_W)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .fast_i     (fast_mode),
    .width_i    (width),
    .sync_evt_o (sync_evt),
    .run_o      (run),
    .cnt_inc_o  (cnt_inc),
    .at_max_o   (at_max),
    .cnt_o      (cnt),
    .ramp_rst_o (ramp_rst_o)
  );

  ssadc_capture #(.NCH(NCH), .CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_evt_i (sync_evt),
    .run_i      (run),
    .at_max_i   (at_max),
    .cnt_i      (cnt),
    .rise_i     (rise),
    .trip_o     (trip),
    .sat_o      (sat),
    .cap_mask_o (cap_mask),
    .ovf_o      (ovf_o),
    .res_flat_o (res_flat)
  );

  assign done_o = &cap_mask;

  ssadc_regs #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW), .DW(DW), .SW_W(SW_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (reg_addr),
    .we_i       (reg_we),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .res_flat_i (res_flat),
    .ovf_i      (ovf_o),
    .done_i     (done_o),
    .fast_o     (fast_mode),
    .aux_sel_o  (aux_sel),
    .trim_o     (trim_o),
    .width_o    (width)
  );

  assign aux_sel_o = aux_sel;

endmodule

// File: rtl/ssadc_timer_chk.sv
module ssadc_timer_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_evt,
  input logic                 run,
  input logic                 cnt_inc,
  input logic                 fast_mode,
  input logic [CNT_W-1:0]     cnt,
  input logic [NCH-1:0]       trip,
  input logic [NCH-1:0]       cap_mask,
  input logic [NCH-1:0]       ovf_o,
  input logic [NCH*CNT_W-1:0] res_flat,
  input logic                 done_o,
  input logic                 ramp_rst_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3
  held_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst_o |-> (cnt == '0));

  // R4
  slow_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !fast_mode) |=> (!cnt_inc || fast_mode));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_evt |=> (cnt >= $past(cnt)));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !sync_evt) |=> (cnt == CNT_MAX));

  // R6
  sticky_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_evt |=> (($past(cap_mask) & ~cap_mask) == '0));

  // R7
  idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sync_evt) |=> $stable(cap_mask));

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !done_o);

  // R6
  one_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip & cap_mask) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R8
    ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[i] |-> (res_flat[i*CNT_W +: CNT_W] == CNT_MAX));

    // R6
    result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mask[i] && !sync_evt) |=> $stable(res_flat[i*CNT_W +: CNT_W]));
  end

endmodule

bind ssadc_timer ssadc_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_evt   (sync_evt),
  .run        (run),
  .cnt_inc    (cnt_inc),
  .fast_mode  (fast_mode),
  .cnt        (cnt),
  .trip       (trip),
  .cap_mask   (cap_mask),
  .ovf_o      (ovf_o),
  .res_flat   (res_flat),
  .done_o     (done_o),
  .ramp_rst_o (ramp_rst_o)
);

// File: tb/ssadc_timer_test.sv
module ssadc_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int MAXV       = 4095;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [3:0]  cmp_i = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ramp_rst_o;
  logic [1:0]  aux_sel_o;
  logic [2:0]  trim_o;
  logic        done_o;
  logic [3:0]  ovf_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssadc_timer uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cmp_i(cmp_i),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ramp_rst_o(ramp_rst_o), .aux_sel_o(aux_sel_o), .trim_o(trim_o),
    .done_o(done_o), .ovf_o(ovf_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 16'(d); reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    @(posedge clk);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  function automatic int weff(input int w);
    return (w < 1) ? 1 : w;
  endfunction

  // expected capture for an edge driven after start edge + d
  function automatic int expv(input int d, input int w, input bit fast);
    int j = d + 2 - weff(w);
    int v = fast ? j : j / 2;
    return (v > MAXV) ? MAXV : v;
  endfunction

  // leaves the caller at the falling edge just after the start edge
  task automatic start_conv();
    @(negedge clk);
    sync_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    int n = 0;
    while (!done_o && n < 10000) begin
      @(negedge clk);
      n++;
    end
    got = done_o;
  endtask

  task automatic conv(input bit fast, input int w, input int d0, input int d1,
                      input int d2, input int d3);
    int d[NCH];
    int bad = 0;
    int v;
    int keep[NCH];
    bit got;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    wr(0, fast ? 16'h0080 : 16'h0000);
    wr(2, w);
    cmp_i = '0;
    repeat (4) @(negedge clk);
    start_conv();
    for (int t = 0; t < 24; t++) begin
      if (ramp_rst_o !== (t < weff(w))) bad++;
      for (int i = 0; i < NCH; i++) if (d[i] == t) cmp_i[i] = 1'b1;
      @(negedge clk);
    end
    check(bad == 0, "R3 discharge length", bad, 0);
    wait_done(got);
    check(got, "R9 done after all trips", int'(got), 1);
    for (int i = 0; i < NCH; i++) begin
      rd(4 + i, v);
      keep[i] = v;
      // R4 count rate, R5 capture timing
      check(v == expv(d[i], w, fast), "R5 captured count", v, expv(d[i], w, fast));
    end
    cmp_i = '0;
    repeat (4) @(negedge clk);
    cmp_i = '1;
    repeat (6) @(negedge clk);
    bad = 0;
    for (int i = 0; i < NCH; i++) begin
      rd(4 + i, v);
      if (v != keep[i]) bad++;
    end
    check(bad == 0, "R6 later toggles ignored", bad, 0);
    cmp_i = '0;
  endtask

  initial begin
    int v;
    bit got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and edges before any start pulse
    check(ramp_rst_o == 0 && done_o == 0 && ovf_o == 0, "R1 reset outputs",
          int'({ramp_rst_o, done_o, ovf_o}), 0);
    check(aux_sel_o == 0 && trim_o == 0, "R1 reset mode outputs", int'({aux_sel_o, trim_o}), 0);
    cmp_i = '1;
    repeat (6) @(negedge clk);
    cmp_i = '0;
    for (int a = 3; a < 8; a++) begin
      rd(a, v);
      check(v == 0, "R1 reset read", v, 0);
    end

    // R2 register fields
    wr(0, 16'hFFFF);
    rd(0, v);
    check(v == 16'h0083, "R2 mode readback", v, 16'h0083);
    for (int s = 0; s < 4; s++) begin
      wr(0, s);
      check(int'(aux_sel_o) == s, "R2 aux select", int'(aux_sel_o), s);
    end
    for (int t = 0; t < 8; t++) begin
      wr(1, 16'hFFF8 | t);
      check(int'(trim_o) == t, "R2 trim drive", int'(trim_o), t);
    end
    rd(1, v);
    check(v == 7, "R2 trim readback", v, 7);
    wr(2, 16'hAB5C);
    rd(2, v);
    check(v == 16'h005C, "R2 width readback", v, 16'h005C);

    // R3 zero width gives one discharge cycle
    wr(2, 0);
    start_conv();
    check(ramp_rst_o == 1'b1, "R3 zero width first cycle", int'(ramp_rst_o), 1);
    @(negedge clk);
    check(ramp_rst_o == 1'b0, "R3 zero width ends", int'(ramp_rst_o), 0);

    // R4 R5 R6 sweep over rate, width and edge placement
    for (int f = 0; f < 2; f++) begin
      for (int wi = 0; wi < 5; wi++) begin
        int w;
        int lo;
        w = (wi == 0) ? 1 : (wi == 1) ? 2 : (wi == 2) ? 3 : (wi == 3) ? 5 : 8;
        lo = (w >= 2) ? w - 2 : 0;
        conv(f[0], w, lo, lo + 2, w + 3, w + 7);
        conv(f[0], w, w + 5, lo + 1, w + 1, w + 10);
        conv(f[0], w, lo, lo, lo, lo);
      end
    end

    // R7 edge inside discharge is dropped, a later edge counts
    wr(0, 16'h0080);
    wr(2, 6);
    cmp_i = '0;
    repeat (4) @(negedge clk);
    start_conv();
    for (int t = 0; t < 20; t++) begin
      if (t == 1)  cmp_i[0] = 1'b1;
      if (t == 8)  cmp_i[0] = 1'b0;
      if (t == 12) cmp_i[0] = 1'b1;
      if (t == 10) cmp_i[3:1] = 3'b111;
      @(negedge clk);
    end
    wait_done(got);
    rd(4, v);
    check(v == expv(12, 6, 1'b1), "R7 second edge captured", v, expv(12, 6, 1'b1));
    rd(7, v);
    check(v == expv(10, 6, 1'b1), "R7 neighbour channel", v, expv(10, 6, 1'b1));

    // R10 writes to status and result addresses are ignored
    for (int a = 3; a < 8; a++) wr(a, 16'h5A5A);
    rd(4, v);
    check(v == expv(12, 6, 1'b1), "R10 result unchanged", v, expv(12, 6, 1'b1));
    rd(3, v);
    check(v == 1, "R10 status unchanged", v, 1);

    // R11 restart mid conversion
    cmp_i = '0;
    wr(2, 2);
    repeat (4) @(negedge clk);
    start_conv();
    for (int t = 0; t < 8; t++) begin
      if (t == 3) cmp_i[1] = 1'b1;
      @(negedge clk);
    end
    cmp_i = '0;
    repeat (4) @(negedge clk);
    start_conv();
    check(done_o == 1'b0, "R11 done low after restart", int'(done_o), 0);
    rd(5, v);
    check(v == 0, "R11 old result cleared", v, 0);

    // R8 saturation with one channel tripping
    wr(0, 16'h0080);
    wr(2, 1);
    repeat (4) @(negedge clk);
    start_conv();
    for (int t = 0; t < 8; t++) begin
      if (t == 5) cmp_i[2] = 1'b1;
      @(negedge clk);
    end
    wait_done(got);
    check(got, "R9 done after saturation", int'(got), 1);
    check(ovf_o == 4'b1011, "R8 overflow flags", int'(ovf_o), 4'b1011);
    rd(6, v);
    check(v == expv(5, 1, 1'b1), "R8 tripped channel no overflow", v, expv(5, 1, 1'b1));
    for (int i = 0; i < NCH; i++) begin
      if (i != 2) begin
        rd(4 + i, v);
        check(v == (16'h8000 | MAXV), "R8 saturated result", v, 16'h8000 | MAXV);
      end
    end
    rd(3, v);
    check(v == ((4'b1011 << 4) | 1), "R9 status word", v, (4'b1011 << 4) | 1);
    cmp_i = '0;
    start_conv();
    check(done_o == 1'b0 && ovf_o == 0, "R9 cleared by start", int'({done_o, ovf_o}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule